// File: doc/BRIEF.md
# Eight-to-One Prefetch Data Serializer

This block is the pin-side data path of a memory device built around an eight-beat prefetch. The core moves one wide word per access, eight beats wide for each data pin. The pin carries one beat per transfer slot. In this model the two-edge pin timing is emulated with an internal clock running at twice the pin clock, so each rising edge of `clk` stands for one pin edge. The core side therefore sees one word per eight `clk` cycles.

A single engine carries the data in both directions. For a read, the engine takes a word from the core and drives it onto the pin one beat at a time, starting with the lowest beat. For a write, it gathers beats from the pin into a word and hands that word to the core, together with a per-half validity mask. Either direction can run a full burst of eight beats or a chopped burst of four. A chopped burst stops after the lower half of the word.

The engine runs one burst at a time. While a burst is in flight, `busy` is high and new requests are dropped. A one-cycle `done` pulse marks the end of every burst.

Top module: `prefetch_serdes`

## Requirements
- R1: After reset, `busy`, `dq_oe`, `done` and `wr_valid` are low and `dq_out` is zero.
- R2: A `rd_req` sampled while `busy` is low loads `rd_word`. In the following cycle `dq_oe` is high, and `dq_out` carries beat 0, which is bits [W-1:0].
- R3: During a read, beat i (bits [i*W +: W]) is on `dq_out` i cycles after beat 0, and `beat_idx` equals i. Beats come out strictly in ascending order.
- R4: A read accepted with `rd_chop` high drives only beats 0 to 3. `dq_oe` falls after beat 3.
- R5: `done` is a one-cycle pulse. `busy` falls in the same cycle. For a read, `done` comes in the cycle after the final beat. For a write, it comes in the cycle after the final beat was captured.
- R6: `busy` is high for the whole burst. A `rd_req` or `wr_start` that arrives while `busy` is high is ignored, so the burst in progress carries on unchanged and no extra burst follows.
- R7: A `wr_start` accepted while idle captures `dq_in` as beat 0 on the same edge, and beat i on the i-th following edge. Beat i lands in bits [i*W +: W] of `wr_word`, which is valid when `wr_valid` pulses together with `done`.
- R8: `wr_mask` bit 0 marks beats 0 to 3 as valid, and bit 1 marks beats 4 to 7. A full write gives mask 2'b11. A write accepted with `wr_chop` high captures 4 beats, gives mask 2'b01, and returns the upper half of `wr_word` as zero.
- R9: When `rd_req` and `wr_start` arrive together while idle, the read is taken and the write request is dropped.
- R10: `dq_out` is zero in every cycle where `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, one rising edge per pin beat |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Core offers a read word |
| rd_chop | input | 1 | Read burst is chopped to 4 beats |
| rd_word | input | W*NBEAT | Word from the core, beat 0 in the low bits |
| dq_out | output | W | Pin data driven on a read |
| dq_oe | output | 1 | Pin driver enable |
| wr_start | input | 1 | Start capturing a write burst; `dq_in` holds beat 0 |
| wr_chop | input | 1 | Write burst is chopped to 4 beats |
| dq_in | input | W | Pin data received on a write |
| wr_word | output | W*NBEAT | Gathered write word, beat 0 in the low bits |
| wr_mask | output | 2 | Per-half validity of `wr_word` |
| wr_valid | output | 1 | `wr_word` and `wr_mask` are valid this cycle |
| beat_idx | output | $clog2(NBEAT) | Index of the beat on the pin during a read |
| done | output | 1 | Burst finished |
| busy | output | 1 | Burst in progress; requests are dropped |

## Verification
The assertions check these rules on every cycle:
- the pin stays quiet whenever its driver is off;
- the driver only switches on after a read request;
- the beat index rises by one on each driven cycle;
- `done` is a single pulse that comes as `busy` falls;
- every write word carries one of the two legal masks, and a chopped write has a zeroed upper half.

Only the bench scenarios can show the rest:
- that each beat matches the right slice of the random word, in order;
- that a chopped burst stops after four beats;
- that requests arriving mid-burst leave no trace;
- that a read wins when both requests come at once.

// File: rtl/prefetch_serdes.sv
`timescale 1ns/1ps
module prefetch_serdes #(
  parameter int W     = 8,
  parameter int NBEAT = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_req,
  input  logic                       rd_chop,
  input  logic [W*NBEAT-1:0]         rd_word,
  output logic [W-1:0]               dq_out,
  output logic                       dq_oe,
  input  logic                       wr_start,
  input  logic                       wr_chop,
  input  logic [W-1:0]               dq_in,
  output logic [W*NBEAT-1:0]         wr_word,
  output logic [1:0]                 wr_mask,
  output logic                       wr_valid,
  output logic [$clog2(NBEAT)-1:0]   beat_idx,
  output logic                       done,
  output logic                       busy
);
  localparam int IW   = $clog2(NBEAT);
  localparam int HALF = NBEAT / 2;
  localparam int WW   = W * NBEAT;

  logic          active, is_wr, chop;
  logic [IW-1:0] cnt;
  logic [WW-1:0] sreg;
  logic [W-1:0]  dq_q;
  logic [W-1:0]  wbuf [NBEAT];

  wire [IW-1:0] last    = chop ? IW'(HALF - 1) : IW'(NBEAT - 1);
  wire          take_rd = !active && rd_req;
  wire          take_wr = !active && wr_start && !rd_req;
  wire          rd_end  = active && !is_wr && (cnt == last);
  wire          wr_end  = active && is_wr && (cnt == last - IW'(1));

  assign busy     = active;
  assign beat_idx = cnt;
  assign dq_out   = dq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      is_wr    <= 1'b0;
      chop     <= 1'b0;
      cnt      <= '0;
      sreg     <= '0;
      dq_q     <= '0;
      dq_oe    <= 1'b0;
      done     <= 1'b0;
      wr_valid <= 1'b0;
      wr_mask  <= 2'b00;
    end else begin
      done     <= 1'b0;
      wr_valid <= 1'b0;
      if (take_rd) begin
        active <= 1'b1;
        is_wr  <= 1'b0;
        chop   <= rd_chop;
        cnt    <= '0;
        dq_q   <= rd_word[W-1:0];
        sreg   <= rd_word >> W;
        dq_oe  <= 1'b1;
      end else if (take_wr) begin
        active <= 1'b1;
        is_wr  <= 1'b1;
        chop   <= wr_chop;
        cnt    <= '0;
      end else if (rd_end) begin
        active <= 1'b0;
        done   <= 1'b1;
        dq_oe  <= 1'b0;
        dq_q   <= '0;
        cnt    <= '0;
      end else if (wr_end) begin
        active   <= 1'b0;
        done     <= 1'b1;
        wr_valid <= 1'b1;
        wr_mask  <= chop ? 2'b01 : 2'b11;
        cnt      <= '0;
      end else if (active) begin
        cnt <= cnt + IW'(1);
        if (!is_wr) begin
          dq_q <= sreg[W-1:0];
          sreg <= sreg >> W;
        end
      end
    end
  end

  for (genvar s = 0; s < NBEAT; s++) begin : g_slot
    localparam logic [IW:0] SLOT = (IW+1)'(s);
    always_ff @(posedge clk) begin
      if (!rst_n)
        wbuf[s] <= '0;
      else if (take_wr)
        wbuf[s] <= (s == 0) ? dq_in : '0;
      else if (active && is_wr && ({1'b0, cnt} + (IW+1)'(1) == SLOT))
        wbuf[s] <= dq_in;
    end
    assign wr_word[s*W +: W] = wbuf[s];
  end
endmodule

// File: rtl/prefetch_serdes_chk.sv
`timescale 1ns/1ps
module prefetch_serdes_chk #(
  parameter int W     = 8,
  parameter int NBEAT = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_req,
  input logic [W-1:0]             dq_out,
  input logic                     dq_oe,
  input logic [W*NBEAT-1:0]       wr_word,
  input logic [1:0]               wr_mask,
  input logic                     wr_valid,
  input logic [$clog2(NBEAT)-1:0] beat_idx,
  input logic                     done,
  input logic                     busy
);
  localparam int HW = W * NBEAT / 2;

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_out == '0);                                          // R10
  AST_OE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(rd_req));                                   // R2
  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe && $past(dq_oe) |-> beat_idx == $past(beat_idx) + 1'b1);     // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                   // R5
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                             // R5
  AST_WR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> done);                                                // R7
  AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_mask == 2'b11 || wr_mask == 2'b01));              // R8
  AST_CHOP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_mask == 2'b01 |-> wr_word[2*HW-1:HW] == '0);        // R8
endmodule

bind prefetch_serdes prefetch_serdes_chk #(.W(W), .NBEAT(NBEAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .dq_out(dq_out), .dq_oe(dq_oe),
  .wr_word(wr_word), .wr_mask(wr_mask), .wr_valid(wr_valid),
  .beat_idx(beat_idx), .done(done), .busy(busy)
);

// File: tb/prefetch_serdes_bench.sv
`timescale 1ns/1ps
module prefetch_serdes_bench;
  localparam int W  = 8;
  localparam int NB = 8;

  logic clk = 0, rst_n = 0;
  logic rd_req = 0, rd_chop = 0, wr_start = 0, wr_chop = 0;
  logic [W*NB-1:0] rd_word = '0;
  logic [W-1:0] dq_in = '0;
  logic [W-1:0] dq_out;
  logic dq_oe, wr_valid, done, busy;
  logic [W*NB-1:0] wr_word;
  logic [1:0] wr_mask;
  logic [2:0] beat_idx;

  int nvec = 0, nfail = 0;
  bit finished = 0;

  logic [W-1:0]    exp_dq[$];
  logic [2:0]      exp_idx[$];
  logic [W*NB-1:0] exp_word[$];
  logic [1:0]      exp_mask[$];

  always #4 clk = ~clk;

  prefetch_serdes u_prefetch_serdes (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_chop(rd_chop), .rd_word(rd_word),
    .dq_out(dq_out), .dq_oe(dq_oe), .wr_start(wr_start), .wr_chop(wr_chop),
    .dq_in(dq_in), .wr_word(wr_word), .wr_mask(wr_mask), .wr_valid(wr_valid),
    .beat_idx(beat_idx), .done(done), .busy(busy)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (dq_oe) begin
        if (exp_dq.size() == 0) check("R6 unexpected read beat", 1, 0);
        else begin
          check("R3 beat data", dq_out, exp_dq.pop_front());
          check("R3 beat_idx", beat_idx, exp_idx.pop_front());
        end
      end else if (dq_out !== '0) check("R10 dq_out while off", dq_out, 0);
      if (wr_valid) begin
        if (exp_word.size() == 0) check("R6/R9 unexpected write word", 1, 0);
        else begin
          check("R7 write word", wr_word, exp_word.pop_front());
          check("R8 write mask", wr_mask, exp_mask.pop_front());
        end
      end
    end
  end

  task automatic read_burst(input logic [W*NB-1:0] w, input bit ch, input bit intrude, input bit both);
    int last = ch ? 3 : 7;
    for (int i = 0; i <= last; i++) begin
      exp_dq.push_back(w[i*W +: W]);
      exp_idx.push_back(3'(i));
    end
    rd_req = 1; rd_chop = ch; rd_word = w;
    if (both) begin wr_start = 1; dq_in = 8'h5A; end
    for (int i = 1; i <= last + 1; i++) begin
      @(negedge clk);
      rd_req = 0; wr_start = 0; rd_chop = 0; rd_word = ~w;
      if (intrude && i == 2) begin rd_req = 1; wr_start = 1; rd_chop = ~ch; end
      if (i == 1) check("R2 oe after accept", dq_oe, 1);
      check("R6 busy during read", busy, 1);
      check("R5 no early done", done, 0);
    end
    @(negedge clk);
    rd_req = 0; wr_start = 0;
    check(ch ? "R4 oe off after chop" : "R5 oe off", dq_oe, 0);
    check("R5 done after last beat", done, 1);
    check("R5 busy falls", busy, 0);
    @(negedge clk);
    check("R5 done single", done, 0);
  endtask

  task automatic write_burst(input logic [W*NB-1:0] w, input bit ch, input bit intrude);
    int last = ch ? 3 : 7;
    logic [W*NB-1:0] e = ch ? {{(W*NB/2){1'b0}}, w[W*NB/2-1:0]} : w;
    exp_word.push_back(e);
    exp_mask.push_back(ch ? 2'b01 : 2'b11);
    wr_start = 1; wr_chop = ch; dq_in = w[W-1:0];
    for (int i = 1; i <= last; i++) begin
      @(negedge clk);
      wr_start = 0; wr_chop = 0; rd_req = 0;
      dq_in = w[i*W +: W];
      if (intrude && i == 2) begin rd_req = 1; wr_start = 1; rd_word = ~w; end
      check("R6 busy during write", busy, 1);
      check("R5 no early done", done, 0);
    end
    @(negedge clk);
    wr_start = 0; rd_req = 0; dq_in = 8'hC3;
    check("R5 done after final capture", done, 1);
    check("R7 wr_valid with done", wr_valid, 1);
    check("R5 busy falls", busy, 0);
    @(negedge clk);
    check("R5 done single", done, 0);
  endtask

  function automatic logic [W*NB-1:0] rnd();
    return {$urandom, $urandom};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 dq_oe", dq_oe, 0);
    check("R1 done", done, 0);
    check("R1 wr_valid", wr_valid, 0);
    check("R1 dq_out", dq_out, 0);
    rst_n = 1;
    @(negedge clk);

    read_burst(64'h7766554433221100, 0, 0, 0);
    for (int k = 0; k < 4; k++) read_burst(rnd(), 0, 0, 0);
    read_burst(64'hFFEEDDCCBBAA9988, 1, 0, 0);          // R4
    for (int k = 0; k < 3; k++) read_burst(rnd(), 1, 0, 0);
    write_burst(64'h0807060504030201, 0, 0);
    for (int k = 0; k < 4; k++) write_burst(rnd(), 0, 0);
    for (int k = 0; k < 3; k++) write_burst(rnd(), 1, 0);   // R8
    read_burst(rnd(), 0, 1, 0);                          // R6
    write_burst(rnd(), 0, 1);                            // R6
    read_burst(rnd(), 1, 0, 1);                          // R9
    read_burst(rnd(), 0, 0, 1);                          // R9
    for (int k = 0; k < 4; k++) begin
      if (k[0]) write_burst(rnd(), k[1], 0);
      else read_burst(rnd(), k[1], 0, 0);
    end

    repeat (12) @(negedge clk);
    check("R6 no leftover beats", exp_dq.size(), 0);
    check("R7 no leftover words", exp_word.size(), 0);
    finish_run();
  end
endmodule